// File: doc/BRIEF.md
# Seconds-Resolution Watchdog Timer

This block is a watchdog timer that software reaches through an 8-byte window of two 32-bit registers. One word holds control and status. The other holds the timeout, in whole seconds. A prescaler divides the core clock down to a one-second tick. A countdown, loaded from the timeout register, decrements on each tick. Software arms the timer by writing the timeout and then, in one control write, setting the run bit together with the kick bit. From then on it must keep writing the kick bit before the countdown runs out.

When the countdown reaches zero, the block issues a fixed-length request pulse. The pulse goes to the system-reset output or to the power-off output, as a control bit selects, and the timer drops out of the running state. A sticky "expired" flag records the event. That flag lives in the power-on reset domain, so the warm reset that the pulse usually triggers does not clear it. A global disable input freezes the countdown and is visible in the status word.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, the control word (byte offset 0) reads 0, except that bit 3 mirrors `global_disable`. The timeout word (byte offset 4) reads `DEFAULT_SECS`.
- R2: The timeout word holds a 10-bit count in bits 9:0. A written 0 is stored as 1. Bits 31:10 are ignored on write and read back as 0.
- R3: Control bit 0 (run) and bit 2 (action) read back as written. Bit 7 (kick) always reads 0.
- R4: Writing 1 to control bit 7 reloads the countdown from the timeout word and restarts the prescaler. If no further kick arrives and the timer keeps running, the expiry pulse starts T*CYCLES_PER_SEC clock cycles after the kick's write edge, where T is the timeout.
- R5: On expiry, exactly one request output is high for PULSE_CYCLES cycles: `reset_req` when bit 2 is 0, or `poweroff_req` when bit 2 is 1. The two are never high together.
- R6: Expiry clears the run bit.
- R7: Expiry sets control bit 1 (expired). `rst` does not clear it. Only `por_rst` or a write of 1 to bit 1 clears it; a write of 0 to bit 1 leaves it unchanged.
- R8: Writing 0 to bit 0 stops the countdown, and no expiry follows.
- R9: While `global_disable` is high, control bit 3 reads 1 and the countdown and prescaler are frozen. Once the input drops, counting resumes with a full second: CYCLES_PER_SEC enabled cycles per tick.
- R10: A timeout written while the timer runs does not change the countdown in progress. It takes effect only at the next kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high warm reset |
| por_rst | input | 1 | Synchronous active-high power-on reset (expired flag and pulse) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte address within the window; bit 2 selects the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| global_disable | input | 1 | Freezes the timer |
| reset_req | output | 1 | System-reset request pulse |
| poweroff_req | output | 1 | Power-off request pulse |

## Verification
The assertions check on every cycle that the two request outputs are never high together, that a pulse begins on the cycle after expiry, and that expiry drops the run bit and sets the expired flag. They also check that a kick reloads the countdown, that the countdown holds while disabled or stopped, and that the stored timeout is never zero. Only the bench scenarios can show the absolute timing of expiry against the kick that armed it. The same is true of repeated kicks that keep the system alive, a late timeout write that must wait for the next kick, the expired flag surviving a warm reset, and the full-second restart after the global disable is released.

// File: rtl/sec_wdt_pkg.sv
package sec_wdt_pkg;

    localparam int BUS_W    = 32;
    localparam int CNT_W    = 10;
    localparam int ADDR_W   = 3;
    localparam int WORD_BIT = 2;

    // control word bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_FIRED = 1;
    localparam int CB_ACT   = 2;
    localparam int CB_DIS   = 3;
    localparam int CB_KICK  = 7;

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } wdt_action_e;

    // fields extracted from a control write
    typedef struct packed {
        logic        run;
        logic        fired_w1c;
        wdt_action_e act;
        logic        kick;
    } ctrl_wr_t;

    // live state presented in the control word
    typedef struct packed {
        logic        running;
        logic        fired;
        wdt_action_e act;
        logic        disabled;
    } ctrl_rd_t;

    function automatic ctrl_wr_t decode_ctrl(input logic [BUS_W-1:0] w);
        ctrl_wr_t f;
        f.run       = w[CB_RUN];
        f.fired_w1c = w[CB_FIRED];
        f.act       = wdt_action_e'(w[CB_ACT]);
        f.kick      = w[CB_KICK];
        return f;
    endfunction

    function automatic logic [BUS_W-1:0] encode_ctrl(input ctrl_rd_t s);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[CB_RUN]   = s.running;
        w[CB_FIRED] = s.fired;
        w[CB_ACT]   = s.act;
        w[CB_DIS]   = s.disabled;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] sanitize_count(input logic [BUS_W-1:0] w);
        logic [CNT_W-1:0] v;
        v = w[CNT_W-1:0];
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/sec_wdt_regif.sv
module sec_wdt_regif
    import sec_wdt_pkg::*;
#(
    parameter int DEFAULT_SECS = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              global_disable,
    input  logic              expire,
    input  logic              fired,
    output logic              running,
    output wdt_action_e       action,
    output logic              kick,
    output logic              fired_clr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] CNT_RESET = sanitize_count(BUS_W'(DEFAULT_SECS));

    logic     wr_ctrl;
    logic     wr_cnt;
    ctrl_wr_t wf;
    ctrl_rd_t rs;

    assign wr_ctrl   = wr_en && !addr[WORD_BIT];
    assign wr_cnt    = wr_en &&  addr[WORD_BIT];
    assign wf        = decode_ctrl(wdata);
    assign kick      = wr_ctrl && wf.kick;
    assign fired_clr = wr_ctrl && wf.fired_w1c;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            action  <= ACT_RESET;
            count   <= CNT_RESET;
        end else begin
            if (expire) begin
                running <= 1'b0;
            end else if (wr_ctrl) begin
                running <= wf.run;
            end
            if (wr_ctrl) begin
                action <= wf.act;
            end
            if (wr_cnt) begin
                count <= sanitize_count(wdata);
            end
        end
    end

    always_comb begin
        rs.running  = running;
        rs.fired    = fired;
        rs.act      = action;
        rs.disabled = global_disable;
        if (addr[WORD_BIT]) begin
            rdata = {{(BUS_W-CNT_W){1'b0}}, count};
        end else begin
            rdata = encode_ctrl(rs);
        end
    end

    AST_RUN_DROPS_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running);                                          // R6
    AST_COUNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (count != '0));                                     // R2

endmodule

// File: rtl/sec_wdt_prescaler.sv
module sec_wdt_prescaler #(
    parameter int CYCLES_PER_SEC = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    output logic tick
);

    localparam int PW = (CYCLES_PER_SEC > 1) ? $clog2(CYCLES_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_SEC - 1);

    logic [PW-1:0] div_q;

    assign tick = enable && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        div_q <= LAST);                                                // R9

endmodule

// File: rtl/sec_wdt_countdown.sv
module sec_wdt_countdown
    import sec_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] remain_q;

    assign expire = enable && tick && !load && (remain_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (enable && tick) begin
            remain_q <= (remain_q <= CNT_W'(1)) ? '0 : remain_q - CNT_W'(1);
        end
    end

    AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain_q == $past(load_val)));                       // R4
    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load) |=> $stable(remain_q));                     // R8

endmodule

// File: rtl/sec_wdt_action.sv
module sec_wdt_action
    import sec_wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        expire,
    input  wdt_action_e action,
    input  logic        fired_clr,
    output logic        fired,
    output logic        reset_req,
    output logic        poweroff_req
);

    localparam int PCW = $clog2(PULSE_CYCLES + 1);

    logic [PCW-1:0] pulse_q;
    wdt_action_e    sel_q;
    logic           active;

    assign active       = (pulse_q != '0);
    assign reset_req    = active && (sel_q == ACT_RESET);
    assign poweroff_req = active && (sel_q == ACT_POWEROFF);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            pulse_q <= '0;
            sel_q   <= ACT_RESET;
            fired   <= 1'b0;
        end else begin
            if (expire) begin
                pulse_q <= PCW'(PULSE_CYCLES);
                sel_q   <= action;
            end else if (active) begin
                pulse_q <= pulse_q - PCW'(1);
            end
            if (expire) begin
                fired <= 1'b1;
            end else if (fired_clr) begin
                fired <= 1'b0;
            end
        end
    end

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (por_rst)
        !(reset_req && poweroff_req));                                 // R5
    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (por_rst)
        expire |=> (reset_req || poweroff_req));                       // R5
    AST_FIRED_ON_EXPIRY: assert property (@(posedge clk) disable iff (por_rst)
        expire |=> fired);                                             // R7

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
    import sec_wdt_pkg::*;
#(
    parameter int CYCLES_PER_SEC = 125_000_000,
    parameter int PULSE_CYCLES   = 16,
    parameter int DEFAULT_SECS   = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              global_disable,
    output logic              reset_req,
    output logic              poweroff_req
);

    logic             running;
    wdt_action_e      action;
    logic             kick;
    logic             fired_clr;
    logic             fired;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             tick;
    logic             count_en;

    assign count_en = running && !global_disable;

    sec_wdt_regif #(.DEFAULT_SECS(DEFAULT_SECS)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .addr           (addr),
        .wdata          (wdata),
        .rdata          (rdata),
        .global_disable (global_disable),
        .expire         (expire),
        .fired          (fired),
        .running        (running),
        .action         (action),
        .kick           (kick),
        .fired_clr      (fired_clr),
        .count          (count)
    );

    sec_wdt_prescaler #(.CYCLES_PER_SEC(CYCLES_PER_SEC)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .enable  (count_en),
        .restart (kick),
        .tick    (tick)
    );

    sec_wdt_countdown u_cd (
        .clk      (clk),
        .rst      (rst),
        .enable   (count_en),
        .tick     (tick),
        .load     (kick),
        .load_val (count),
        .expire   (expire)
    );

    sec_wdt_action #(.PULSE_CYCLES(PULSE_CYCLES)) u_act (
        .clk          (clk),
        .por_rst      (por_rst),
        .expire       (expire),
        .action       (action),
        .fired_clr    (fired_clr),
        .fired        (fired),
        .reset_req    (reset_req),
        .poweroff_req (poweroff_req)
    );

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (rst)
        global_disable |-> !expire);                                   // R9

endmodule

// File: tb/tb_sec_watchdog.sv
module tb_sec_watchdog;

    localparam int CPS   = 10;
    localparam int PULSE = 4;
    localparam int DEF   = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        global_disable = 1'b0;
    logic        reset_req;
    logic        poweroff_req;

    sec_watchdog #(.CYCLES_PER_SEC(CPS), .PULSE_CYCLES(PULSE), .DEFAULT_SECS(DEF)) dut (
        .clk(clk), .rst(rst), .por_rst(por_rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .global_disable(global_disable),
        .reset_req(reset_req), .poweroff_req(poweroff_req)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int    at;
        bit    po;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   wr_cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_cyc = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic push(input int at, input bit po, input string req);
        exp_t e;
        e.at = at; e.po = po; e.req = req;
        q.push_back(e);
    endtask

    // monitor: pulse start events and pulse width
    logic prev_r = 1'b0, prev_p = 1'b0;
    int   hi = 0;
    always @(negedge clk) begin
        if (!por_rst) begin
            if ((reset_req && !prev_r) || (poweroff_req && !prev_p)) begin
                if (q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R8: unexpected request pulse at cycle %0d, expected none", cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.req, " pulse cycle"}, cyc, e.at);
                    chk("R5 pulse output", {31'b0, poweroff_req}, {31'b0, e.po});
                    chk("R5 exclusive", {31'b0, reset_req && poweroff_req}, 32'd0);
                end
            end
            if (reset_req || poweroff_req) hi++;
            else if (hi != 0) begin
                chk("R5 pulse width", hi, PULSE);
                hi = 0;
            end
        end
        prev_r = reset_req;
        prev_p = poweroff_req;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0; por_rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
        rd(3'd4, d); chk("R1 count", d, DEF);
        global_disable = 1'b1;
        rd(3'd0, d); chk("R1 disable bit", d, 32'h8);
        global_disable = 1'b0;

        // R2 count sanitizing
        wr(3'd4, 32'h0);         rd(3'd4, d); chk("R2 zero->1", d, 32'd1);
        wr(3'd4, 32'hFFFF_FC05); rd(3'd4, d); chk("R2 upper bits", d, 32'd5);
        wr(3'd4, 32'd2000);      rd(3'd4, d); chk("R2 truncate", d, 32'd976);

        // R3 kick reads zero, action read-back
        wr(3'd0, 32'h84); rd(3'd0, d); chk("R3 act/kick", d, 32'h4);
        wr(3'd0, 32'h00); rd(3'd0, d); chk("R3 clear", d, 32'h0);

        // R4/R6 basic expiry to reset
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h81);
        push(wr_cyc + 2 * CPS, 1'b0, "R4");
        rd(3'd0, d); chk("R3 running", d, 32'h1);
        repeat (30) @(negedge clk);
        chk("R4 expiry seen", q.size(), 0);
        rd(3'd0, d); chk("R6 run cleared R7 fired", d, 32'h2);

        // R7 fired survives warm reset, W1C
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        rd(3'd0, d); chk("R7 survives rst", d, 32'h2);
        wr(3'd0, 32'h00); rd(3'd0, d); chk("R7 write0 keeps", d, 32'h2);
        wr(3'd0, 32'h02); rd(3'd0, d); chk("R7 w1c", d, 32'h0);

        // R4 repeated kicks keep it alive
        wr(3'd4, 32'd3);
        wr(3'd0, 32'h81);
        for (int i = 0; i < 5; i++) begin
            repeat (15) @(negedge clk);
            wr(3'd0, 32'h81);
        end
        push(wr_cyc + 3 * CPS, 1'b0, "R4 kicked");
        repeat (45) @(negedge clk);
        chk("R4 kicked expiry", q.size(), 0);
        wr(3'd0, 32'h02);

        // R5 power-off action
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h85);
        push(wr_cyc + CPS, 1'b1, "R5");
        repeat (20) @(negedge clk);
        chk("R5 poweroff seen", q.size(), 0);
        rd(3'd0, d); chk("R5 state after", d, 32'h6);
        wr(3'd0, 32'h02);

        // R8 stop prevents expiry
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h81);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'h00);
        repeat (50) @(negedge clk);
        rd(3'd0, d); chk("R8 stopped no fire", d, 32'h0);

        // R9 global disable freezes, resumes with full second
        global_disable = 1'b1;
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h81);
        repeat (40) @(negedge clk);
        rd(3'd0, d); chk("R9 frozen", d, 32'h9);
        @(negedge clk); global_disable = 1'b0;
        @(posedge clk); #1; c1 = cyc;
        push(c1 + CPS - 1, 1'b0, "R9");
        repeat (20) @(negedge clk);
        chk("R9 resumed expiry", q.size(), 0);
        wr(3'd0, 32'h02);

        // R10 count write while running deferred
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h81);
        push(wr_cyc + 2 * CPS, 1'b0, "R10");
        repeat (3) @(negedge clk);
        wr(3'd4, 32'd1);
        rd(3'd4, d); chk("R10 stored", d, 32'd1);
        repeat (30) @(negedge clk);
        chk("R10 deferred expiry", q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule